// File: doc/BRIEF.md
# Power Management Capability Register File

This block holds the handful of configuration-space words that a PCI-style target function needs in order to take part in system power management. It answers configuration reads and writes addressed by dword index with per-byte enables. It holds the power-state field, the wake-enable bit and the sticky wake-status bit. It turns those into an active-low wake request and a 2-bit power-state output for the rest of the function.

The wake logic of the function pulses `wake_evt` whenever something should wake the system. The status bit records that pulse even while waking is disabled, so software can see that an event happened. The wake request line is pulled low only while the status bit and the enable bit are both set. Software acknowledges the event by writing a 1 to the status bit. At the first clock after reset is released, the block also captures subsystem identifiers from strap pins. It serves a constant capability pointer and a constant capability word. Every other offset reads as zero.

Top module: `pm_cfg_regs`

## Requirements
- R1: A read of byte offset 34h (dword index 0Dh) returns 00000040h.
- R2: A read of byte offset 40h (dword index 10h) returns 6C210001h, and writes to that offset change nothing.
- R3: Bits [1:0] of offset 44h (index 11h) are the power state, read/write through byte enable bit 0. The encoding is 00 = D0, 01 = D1, 10 = D2, 11 = D3hot, and the field drives `pwr_state`. A write with that byte enable clear leaves the field unchanged.
- R4: Bit 8 of offset 44h is the wake enable, read/write through byte enable bit 1.
- R5: Bit 15 of offset 44h is the wake status. It becomes 1 on the clock edge after `wake_evt` is high, whatever the enable bit holds.
- R6: Writing 1 to bit 15 with byte enable bit 1 set clears the status bit. Writing 0 to it leaves the bit unchanged.
- R7: If a wake event and a clearing write fall in the same cycle, the status bit stays 1.
- R8: `pme_n` is 0 exactly while the status bit and the enable bit are both 1. It is 1 whenever the enable bit is 0.
- R9: Offset 2Ch (index 0Bh) returns the address straps in bits [19:16] and the data straps in bits [7:0]. The straps are captured at the first clock edge after the internal reset is released. All other bits read 0, and writes are ignored.
- R10: Reset clears the power state to D0 and clears the enable and status bits, so `pme_n` is 1 and `pwr_state` is 00.
- R11: Every dword index other than 0Bh, 0Dh, 10h and 11h reads 00000000h, and writes to those indexes have no visible effect.
- R12: All bits of offset 44h other than 15, 8 and 1:0 read 0, even after writing all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | 6 | Dword index of the configuration access |
| cfg_be | input | 4 | Byte enables of the write, bit n for byte lane n |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| wake_evt | input | 1 | Wake event pulse from the function's wake logic |
| strap_sub | input | 4 | Subsystem ID straps, captured after reset |
| strap_svid | input | 8 | Subvendor ID straps, captured after reset |
| pme_n | output | 1 | Active-low wake request |
| pwr_state | output | 2 | Current power state |

## Verification
The wake status bit has two writers that can act in the same cycle: the event input that sets it and the software write-one that clears it. The bench drives a write of 1 to bit 15 in the same cycle as a `wake_evt` pulse, with the enable bit set. It then expects the status to read back as 1 and `pme_n` to stay low, because an event must never be lost. Separate single-source cycles show that each writer alone behaves as expected: the event sets the bit and the write clears it.

// File: rtl/pm_cfg_pkg.sv
package pm_cfg_pkg;

  // byte offsets of the implemented configuration words
  localparam logic [7:0] OFF_SUBID  = 8'h2C;
  localparam logic [7:0] OFF_CAPPTR = 8'h34;
  localparam logic [7:0] OFF_PMCAP  = 8'h40;
  localparam logic [7:0] OFF_PMCSR  = 8'h44;

  // bit positions inside the control/status word
  localparam int unsigned PS_LSB  = 0;
  localparam int unsigned EN_BIT  = 8;
  localparam int unsigned STS_BIT = 15;

  typedef enum logic [1:0] {
    PS_D0    = 2'b00,
    PS_D1    = 2'b01,
    PS_D2    = 2'b10,
    PS_D3HOT = 2'b11
  } pstate_e;

  typedef struct packed {
    logic    sts;
    logic    en;
    pstate_e ps;
  } pmcsr_t;

endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/pm_strap_latch.sv
module pm_strap_latch #(
  parameter int unsigned SUB_W  = 4,
  parameter int unsigned SVID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SUB_W-1:0]  strap_sub,
  input  logic [SVID_W-1:0] strap_svid,
  output logic [SUB_W-1:0]  sub_id,
  output logic [SVID_W-1:0] svid
);

  // floating straps resolve to an ID of one
  localparam logic [SUB_W-1:0]  SUB_FLOAT  = SUB_W'(1);
  localparam logic [SVID_W-1:0] SVID_FLOAT = SVID_W'(1);

  logic              pend_q;
  logic              pend_d;
  logic              cap_en;
  logic [SUB_W-1:0]  sub_q;
  logic [SVID_W-1:0] svid_q;

  always_comb begin
    cap_en = pend_q;
    pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
    end else if (cap_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= SUB_FLOAT;
      svid_q <= SVID_FLOAT;
    end else if (cap_en) begin
      sub_q  <= strap_sub;
      svid_q <= strap_svid;
    end
  end

  assign sub_id = sub_q;
  assign svid   = svid_q;

endmodule

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg
  import pm_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [1:0] wr_be,
  input  logic [1:0] wr_ps,
  input  logic       wr_en,
  input  logic       wr_sts,
  input  logic       wake_evt,
  output pmcsr_t     csr
);

  pmcsr_t csr_q;
  pmcsr_t csr_d;
  logic   ps_ce;
  logic   en_ce;
  logic   sts_ce;
  logic   sts_clr;

  always_comb begin
    ps_ce   = wr_hit && wr_be[0];
    en_ce   = wr_hit && wr_be[1];
    sts_clr = wr_hit && wr_be[1] && wr_sts;
    sts_ce  = wake_evt || sts_clr;
    csr_d    = csr_q;
    csr_d.ps = pstate_e'(wr_ps);
    csr_d.en = wr_en;
    // a new event outranks a clearing write in the same cycle
    csr_d.sts = wake_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q.ps <= PS_D0;
    end else if (ps_ce) begin
      csr_q.ps <= csr_d.ps;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q.en <= 1'b0;
    end else if (en_ce) begin
      csr_q.en <= csr_d.en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q.sts <= 1'b0;
    end else if (sts_ce) begin
      csr_q.sts <= csr_d.sts;
    end
  end

  assign csr = csr_q;

endmodule

// File: rtl/pm_cfg_rdmux.sv
module pm_cfg_rdmux
  import pm_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned SUB_W    = 4,
  parameter int unsigned SVID_W   = 8,
  parameter logic [7:0]  CAP_PTR  = 8'h40,
  parameter logic [31:0] CAP_WORD = 32'h6C210001
) (
  input  logic [ADDR_W-1:0] addr,
  input  pmcsr_t            csr,
  input  logic [SUB_W-1:0]  sub_id,
  input  logic [SVID_W-1:0] svid,
  output logic [31:0]       rdata
);

  localparam logic [ADDR_W-1:0] IDX_SUBID  = ADDR_W'(OFF_SUBID >> 2);
  localparam logic [ADDR_W-1:0] IDX_CAPPTR = ADDR_W'(OFF_CAPPTR >> 2);
  localparam logic [ADDR_W-1:0] IDX_PMCAP  = ADDR_W'(OFF_PMCAP >> 2);
  localparam logic [ADDR_W-1:0] IDX_PMCSR  = ADDR_W'(OFF_PMCSR >> 2);
  localparam int unsigned       SUB_LSB    = 16;

  always_comb begin
    rdata = '0;
    case (addr)
      IDX_SUBID: begin
        rdata[SUB_LSB +: SUB_W] = sub_id;
        rdata[SVID_W-1:0]       = svid;
      end
      IDX_CAPPTR: rdata[7:0] = CAP_PTR;
      IDX_PMCAP:  rdata      = CAP_WORD;
      IDX_PMCSR: begin
        rdata[STS_BIT]         = csr.sts;
        rdata[EN_BIT]          = csr.en;
        rdata[PS_LSB +: 2]     = csr.ps;
      end
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
  import pm_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned SUB_W     = 4,
  parameter int unsigned SVID_W    = 8,
  parameter int unsigned RST_STAGE = 2,
  parameter logic [7:0]  CAP_PTR   = 8'h40,
  parameter logic [31:0] CAP_WORD  = 32'h6C210001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              wake_evt,
  input  logic [SUB_W-1:0]  strap_sub,
  input  logic [SVID_W-1:0] strap_svid,
  output logic              pme_n,
  output logic [1:0]        pwr_state
);

  localparam logic [ADDR_W-1:0] IDX_PMCSR = ADDR_W'(OFF_PMCSR >> 2);

  logic              rst_sync_n;
  logic              csr_hit;
  pmcsr_t            csr_q;
  logic [SUB_W-1:0]  sub_id;
  logic [SVID_W-1:0] svid;
  logic              unused_wbits;

  assign csr_hit = cfg_wr && (cfg_addr == IDX_PMCSR);

  pm_rst_sync #(
    .STAGES (RST_STAGE)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pm_strap_latch #(
    .SUB_W  (SUB_W),
    .SVID_W (SVID_W)
  ) u_strap (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .strap_sub  (strap_sub),
    .strap_svid (strap_svid),
    .sub_id     (sub_id),
    .svid       (svid)
  );

  pm_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_hit   (csr_hit),
    .wr_be    (cfg_be[1:0]),
    .wr_ps    (cfg_wdata[PS_LSB +: 2]),
    .wr_en    (cfg_wdata[EN_BIT]),
    .wr_sts   (cfg_wdata[STS_BIT]),
    .wake_evt (wake_evt),
    .csr      (csr_q)
  );

  pm_cfg_rdmux #(
    .ADDR_W   (ADDR_W),
    .SUB_W    (SUB_W),
    .SVID_W   (SVID_W),
    .CAP_PTR  (CAP_PTR),
    .CAP_WORD (CAP_WORD)
  ) u_rdmux (
    .addr   (cfg_addr),
    .csr    (csr_q),
    .sub_id (sub_id),
    .svid   (svid),
    .rdata  (cfg_rdata)
  );

  assign pme_n     = ~(csr_q.sts & csr_q.en);
  assign pwr_state = csr_q.ps;

  assign unused_wbits = ^{cfg_be[3:2], cfg_wdata[31:16], cfg_wdata[14:9], cfg_wdata[7:2]};

endmodule

// File: rtl/pm_cfg_regs_chk.sv
module pm_cfg_regs_chk
  import pm_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [3:0]        cfg_be,
  input logic [31:0]       cfg_wdata,
  input logic [31:0]       cfg_rdata,
  input logic              wake_evt,
  input logic              pme_n,
  input logic [1:0]        pwr_state,
  input logic              pme_sts,
  input logic              pme_en
);

  localparam logic [ADDR_W-1:0] I_SUB = ADDR_W'(OFF_SUBID >> 2);
  localparam logic [ADDR_W-1:0] I_PTR = ADDR_W'(OFF_CAPPTR >> 2);
  localparam logic [ADDR_W-1:0] I_CAP = ADDR_W'(OFF_PMCAP >> 2);
  localparam logic [ADDR_W-1:0] I_CSR = ADDR_W'(OFF_PMCSR >> 2);

  logic hit;
  logic clr_req;
  assign hit     = cfg_wr && (cfg_addr == I_CSR);
  assign clr_req = hit && cfg_be[1] && cfg_wdata[STS_BIT];

  a_r1_cap_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == I_PTR) |-> (cfg_rdata == 32'h0000_0040));

  a_r3_state_write: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cfg_be[0]) |=> (pwr_state == $past(cfg_wdata[1:0])));

  a_r4_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cfg_be[1]) |=> (pme_en == $past(cfg_wdata[EN_BIT])));

  a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> pme_sts);

  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !wake_evt) |=> !pme_sts);

  a_r6_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pme_sts && !clr_req) |=> pme_sts);

  a_r8_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cfg_be[1] && !cfg_wdata[EN_BIT]) |=> pme_n);

  a_r11_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_addr != I_SUB) && (cfg_addr != I_PTR) && (cfg_addr != I_CAP) &&
     (cfg_addr != I_CSR)) |-> (cfg_rdata == 32'h0));

endmodule

bind pm_cfg_regs pm_cfg_regs_chk #(
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cfg_wr    (cfg_wr),
  .cfg_addr  (cfg_addr),
  .cfg_be    (cfg_be),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .wake_evt  (wake_evt),
  .pme_n     (pme_n),
  .pwr_state (pwr_state),
  .pme_sts   (csr_q.sts),
  .pme_en    (csr_q.en)
);

// File: tb/pm_cfg_regs_bench.sv
`timescale 1ns/1ps
module pm_cfg_regs_bench;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [5:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        wake_evt;
  logic [3:0]  strap_sub;
  logic [7:0]  strap_svid;
  logic        pme_n;
  logic [1:0]  pwr_state;

  int n_chk;
  int n_fail;
  bit done;

  pm_cfg_regs u_pm_cfg_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .cfg_be     (cfg_be),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .wake_evt   (wake_evt),
    .strap_sub  (strap_sub),
    .strap_svid (strap_svid),
    .pme_n      (pme_n),
    .pwr_state  (pwr_state)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [7:0]  req;
    logic        wr;
    logic [5:0]  idx;
    logic [3:0]  be;
    logic [31:0] wd;
    logic        evt;
    logic [31:0] exp_rd;
    logic        exp_pme_n;
    logic [1:0]  exp_ps;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{8'd1,  1'b0, 6'h0D, 4'h0, 32'h0,        1'b0, 32'h0000_0040, 1'b1, 2'd0}, // R1
    '{8'd2,  1'b0, 6'h10, 4'h0, 32'h0,        1'b0, 32'h6C21_0001, 1'b1, 2'd0}, // R2
    '{8'd2,  1'b1, 6'h10, 4'hF, 32'hFFFF_FFFF, 1'b0, 32'h6C21_0001, 1'b1, 2'd0}, // R2
    '{8'd9,  1'b0, 6'h0B, 4'h0, 32'h0,        1'b0, 32'h000A_005C, 1'b1, 2'd0}, // R9
    '{8'd9,  1'b1, 6'h0B, 4'hF, 32'hFFFF_FFFF, 1'b0, 32'h000A_005C, 1'b1, 2'd0}, // R9
    '{8'd10, 1'b0, 6'h11, 4'h0, 32'h0,        1'b0, 32'h0000_0000, 1'b1, 2'd0}, // R10
    '{8'd3,  1'b1, 6'h11, 4'h1, 32'h0000_0003, 1'b0, 32'h0000_0003, 1'b1, 2'd3}, // R3 D3hot
    '{8'd3,  1'b1, 6'h11, 4'h1, 32'h0000_0002, 1'b0, 32'h0000_0002, 1'b1, 2'd2}, // R3 D2
    '{8'd3,  1'b1, 6'h11, 4'h0, 32'h0000_0001, 1'b0, 32'h0000_0002, 1'b1, 2'd2}, // R3 be clear
    '{8'd5,  1'b0, 6'h11, 4'h0, 32'h0,        1'b1, 32'h0000_8002, 1'b1, 2'd2}, // R5 disabled
    '{8'd4,  1'b1, 6'h11, 4'h2, 32'h0000_0100, 1'b0, 32'h0000_8102, 1'b0, 2'd2}, // R4 R6 w0 R8
    '{8'd6,  1'b1, 6'h11, 4'h2, 32'h0000_8100, 1'b0, 32'h0000_0102, 1'b1, 2'd2}, // R6 w1c
    '{8'd7,  1'b1, 6'h11, 4'h2, 32'h0000_8100, 1'b1, 32'h0000_8102, 1'b0, 2'd2}, // R7 collide
    '{8'd8,  1'b1, 6'h11, 4'h2, 32'h0000_0000, 1'b0, 32'h0000_8002, 1'b1, 2'd2}, // R8 disable
    '{8'd3,  1'b1, 6'h11, 4'h1, 32'h0000_0000, 1'b0, 32'h0000_8000, 1'b1, 2'd0}, // R3 D0
    '{8'd11, 1'b0, 6'h00, 4'h0, 32'h0,        1'b0, 32'h0000_0000, 1'b1, 2'd0}, // R11
    '{8'd11, 1'b1, 6'h01, 4'hF, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 1'b1, 2'd0}, // R11
    '{8'd11, 1'b0, 6'h3F, 4'h0, 32'h0,        1'b0, 32'h0000_0000, 1'b1, 2'd0}  // R11
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [5:0] idx, input logic [3:0] be,
                        input logic [31:0] wd, input logic evt);
    @(negedge clk);
    cfg_wr    = wr;
    cfg_addr  = idx;
    cfg_be    = be;
    cfg_wdata = wd;
    wake_evt  = evt;
    @(negedge clk);
    cfg_wr   = 1'b0;
    wake_evt = 1'b0;
    #1;
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_be = '0; cfg_wdata = '0;
    wake_evt = 1'b0; strap_sub = 4'hA; strap_svid = 8'h5C;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].idx, VECS[i].be, VECS[i].wd, VECS[i].evt);
      check($sformatf("R%0d vec%0d rdata", VECS[i].req, i), cfg_rdata, VECS[i].exp_rd);
      check($sformatf("R%0d vec%0d pme_n", VECS[i].req, i), 32'(pme_n), 32'(VECS[i].exp_pme_n));
      check($sformatf("R%0d vec%0d pwr_state", VECS[i].req, i), 32'(pwr_state), 32'(VECS[i].exp_ps));
    end

    // R8: enable, event, then reset mid-request
    access(1'b1, 6'h11, 4'h3, 32'h0000_0103, 1'b1);
    check("R8 request active", 32'(pme_n), 32'h0);
    @(negedge clk);
    strap_sub = 4'h1; strap_svid = 8'h01;
    rst_n = 1'b0;
    #1;
    check("R10 pme_n in reset", 32'(pme_n), 32'h1);
    check("R10 pwr_state in reset", 32'(pwr_state), 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    access(1'b0, 6'h11, 4'h0, 32'h0, 1'b0);
    check("R10 csr after reset", cfg_rdata, 32'h0);
    access(1'b0, 6'h0B, 4'h0, 32'h0, 1'b0);
    check("R9 floating strap ids", cfg_rdata, 32'h0001_0001);

    // R12: all-ones write keeps reserved bits at zero
    access(1'b1, 6'h11, 4'hF, 32'hFFFF_FFFF, 1'b0);
    check("R12 reserved bits", cfg_rdata, 32'h0000_0103);
    access(1'b0, 6'h11, 4'h0, 32'h0, 1'b1);
    check("R8 event with enable", 32'(pme_n), 32'h0);
    check("R5 status after event", cfg_rdata, 32'h0000_8103);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule